// File: doc/BRIEF.md
# Multimode Counter and Shift Register

A four-bit register stage whose behaviour on each rising clock edge is chosen by a three-bit mode select. It can load a preset word, invert its contents, shift one place in either direction, count up or down modulo sixteen, clear itself, or hold. A high level on the asynchronous reset clears the register at once, whatever the clock and the other inputs are doing.

Two inputs and one output each have a double role, so that stages can be chained with one wire between neighbours. The low-order serial input is also the active-low trickle count enable. The terminal count output carries the top data bit while the stage is shifting. When a lower stage's terminal count drives the next stage's serial/trickle input, the chain counts as one wide counter or shifts as one wide register toward the most significant end. A second active-low enable stops counting in every stage at once. The terminal count comes straight from the stored value, the mode and the trickle enable, so enables ripple along the chain within one clock period.

Top module: `mode_counter_shifter`

## Requirements
- R1: While `mreset` is high, `q` is 0 at once, with no clock edge needed. This overrides every other input, including a clock edge in load mode.
- R2: Mode `sel`=000 loads `preset` into `q` on the clock edge, and `tc` is low while this mode is selected.
- R3: Mode `sel`=001 inverts every bit of `q` on the clock edge.
- R4: Mode `sel`=010 shifts toward the LSB: the new `q` is {`ser_hi`, q[3:1]}. `tc` equals q[3] while this mode is selected.
- R5: Mode `sel`=011 shifts toward the MSB: the new `q` is {q[2:0], `ser_lo_cet_n`}. `tc` equals q[3] while this mode is selected.
- R6: Mode `sel`=110 adds 1 modulo 16 on the clock edge only when `cnt_en_n` and `ser_lo_cet_n` are both low. If either is high, `q` is unchanged.
- R7: Mode `sel`=100 subtracts 1 modulo 16 on the clock edge only when `cnt_en_n` and `ser_lo_cet_n` are both low. If either is high, `q` is unchanged.
- R8: In count-up mode `tc` is low exactly when `q`=15 and `ser_lo_cet_n` is low. In count-down mode `tc` is low exactly when `q`=0 and `ser_lo_cet_n` is low. In all other counting cases `tc` is high, whatever `cnt_en_n` is.
- R9: Mode `sel`=101 sets `q` to 0 on the clock edge.
- R10: Mode `sel`=111 keeps `q` unchanged. `tc` is high in the hold, invert and clear modes.
- R11: `q_n` is the bitwise inverse of `q` at all times.
- R12: When two stages are chained, with the lower `tc` driving the upper `ser_lo_cet_n`, the pair counts up and down as one 8-bit counter and shifts toward the MSB as one 8-bit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mreset | input | 1 | Asynchronous clear, active high |
| sel | input | 3 | Mode select |
| cnt_en_n | input | 1 | Parallel count enable, active low |
| ser_lo_cet_n | input | 1 | Serial input for MSB-ward shift; trickle count enable, active low |
| ser_hi | input | 1 | Serial input for LSB-ward shift |
| preset | input | 4 | Parallel load word |
| q | output | 4 | Register contents |
| q_n | output | 4 | Inverse of q |
| tc | output | 1 | Terminal count (active low) or top bit while shifting |

## Verification
A single stage is swept over every mode, every starting value, all four combinations of the two enables and both levels of the high serial input. This covers the wrap points 15 to 0 and 0 to 15 against the held cases, and it tests the trickle enable's effect on `tc` apart from the parallel enable's. Each step also checks `tc` before the edge, which shows whether it follows the mode and the stored value. Two chained stages then count up and down through full 8-bit wraps, and they shift an irregular bit pattern toward the MSB. These runs show whether the carry, the borrow and the shifted-out bit cross the single link in the right cycle. The asynchronous reset is applied between clock edges and held over a load edge, to show that it acts without the clock and takes priority.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [2:0] {
    MODE_LOAD   = 3'b000,
    MODE_INVERT = 3'b001,
    MODE_TO_LSB = 3'b010,
    MODE_TO_MSB = 3'b011,
    MODE_DOWN   = 3'b100,
    MODE_CLEAR  = 3'b101,
    MODE_UP     = 3'b110,
    MODE_HOLD   = 3'b111
  } mode_e;

  typedef struct packed {
    logic load;
    logic invert;
    logic to_lsb;
    logic to_msb;
    logic down;
    logic clear;
    logic up;
    logic hold;
  } mode_flags_t;

endpackage

// File: rtl/mcs_mode_decode.sv
module mcs_mode_decode
  import mcs_pkg::*;
(
  input  logic [2:0]  sel,
  output mode_flags_t flags,
  output logic        is_shift,
  output logic        is_count
);

  mode_e mode;

  always_comb begin
    mode  = mode_e'(sel);
    flags = '0;
    case (mode)
      MODE_LOAD:   flags.load   = 1'b1;
      MODE_INVERT: flags.invert = 1'b1;
      MODE_TO_LSB: flags.to_lsb = 1'b1;
      MODE_TO_MSB: flags.to_msb = 1'b1;
      MODE_DOWN:   flags.down   = 1'b1;
      MODE_CLEAR:  flags.clear  = 1'b1;
      MODE_UP:     flags.up     = 1'b1;
      default:     flags.hold   = 1'b1;
    endcase
  end

  assign is_shift = flags.to_lsb | flags.to_msb;
  assign is_count = flags.up | flags.down;

endmodule

// File: rtl/mcs_next_state.sv
module mcs_next_state
  import mcs_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  mode_flags_t      flags,
  input  logic             advance,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  input  logic             ser_lo,
  input  logic             ser_hi,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  function automatic logic [WIDTH-1:0] step_up(input logic [WIDTH-1:0] v);
    return v + ONE;
  endfunction

  function automatic logic [WIDTH-1:0] step_down(input logic [WIDTH-1:0] v);
    return v - ONE;
  endfunction

  function automatic logic [WIDTH-1:0] push_low(input logic [WIDTH-1:0] v,
                                                input logic b);
    return {v[WIDTH-2:0], b};
  endfunction

  function automatic logic [WIDTH-1:0] push_high(input logic [WIDTH-1:0] v,
                                                 input logic b);
    return {b, v[WIDTH-1:1]};
  endfunction

  always_comb begin
    nxt = cur;
    if (flags.load)                 nxt = preset;
    else if (flags.invert)          nxt = ~cur;
    else if (flags.to_lsb)          nxt = push_high(cur, ser_hi);
    else if (flags.to_msb)          nxt = push_low(cur, ser_lo);
    else if (flags.clear)           nxt = '0;
    else if (flags.up && advance)   nxt = step_up(cur);
    else if (flags.down && advance) nxt = step_down(cur);
    else if (flags.hold)            nxt = cur;
  end

endmodule

// File: rtl/mcs_term_count.sv
module mcs_term_count #(
  parameter int WIDTH = 4
) (
  input  logic             is_load,
  input  logic             is_shift,
  input  logic             is_up,
  input  logic             is_down,
  input  logic             trickle_n,
  input  logic [WIDTH-1:0] cur,
  output logic             tc
);

  function automatic logic at_top(input logic [WIDTH-1:0] v);
    return &v;
  endfunction

  function automatic logic at_bottom(input logic [WIDTH-1:0] v);
    return ~|v;
  endfunction

  logic hit_up;
  logic hit_down;

  assign hit_up   = is_up   & ~trickle_n & at_top(cur);
  assign hit_down = is_down & ~trickle_n & at_bottom(cur);

  always_comb begin
    if (is_load)       tc = 1'b0;
    else if (is_shift) tc = cur[WIDTH-1];
    else               tc = ~(hit_up | hit_down);
  end

endmodule

// File: rtl/mode_counter_shifter.sv
module mode_counter_shifter
  import mcs_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             mreset,
  input  logic [2:0]       sel,
  input  logic             cnt_en_n,
  input  logic             ser_lo_cet_n,
  input  logic             ser_hi,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_n,
  output logic             tc
);

  mode_flags_t      flags;
  logic             is_shift;
  logic             is_count;
  logic             count_advance;
  logic [WIDTH-1:0] q_next;

  assign count_advance = ~cnt_en_n & ~ser_lo_cet_n;

  mcs_mode_decode u_decode (
    .sel      (sel),
    .flags    (flags),
    .is_shift (is_shift),
    .is_count (is_count)
  );

  mcs_next_state #(.WIDTH(WIDTH)) u_next (
    .flags   (flags),
    .advance (count_advance & is_count),
    .cur     (q),
    .preset  (preset),
    .ser_lo  (ser_lo_cet_n),
    .ser_hi  (ser_hi),
    .nxt     (q_next)
  );

  mcs_term_count #(.WIDTH(WIDTH)) u_tc (
    .is_load   (flags.load),
    .is_shift  (is_shift),
    .is_up     (flags.up),
    .is_down   (flags.down),
    .trickle_n (ser_lo_cet_n),
    .cur       (q),
    .tc        (tc)
  );

  always_ff @(posedge clk or posedge mreset) begin
    if (mreset) q <= '0;
    else        q <= q_next;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_inv
    assign q_n[b] = ~q[b];
  end

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             mreset,
  input logic [2:0]       sel,
  input logic             cnt_en_n,
  input logic             ser_lo_cet_n,
  input logic             ser_hi,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] q,
  input logic [WIDTH-1:0] q_n,
  input logic             tc,
  input logic             count_advance
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  a_r1_reset_clears: assert property (@(posedge clk) mreset |-> q == '0);

  a_r2_load: assert property (@(posedge clk) disable iff (mreset)
    sel == 3'b000 |=> q == $past(preset));
  a_r2_tc_low: assert property (@(posedge clk) disable iff (mreset)
    sel == 3'b000 |-> !tc);

  a_r3_invert: assert property (@(posedge clk) disable iff (mreset)
    sel == 3'b001 |=> q == ~$past(q));

  a_r4_to_lsb: assert property (@(posedge clk) disable iff (mreset)
    sel == 3'b010 |=> q == {$past(ser_hi), $past(q[WIDTH-1:1])});
  a_r4_tc_top: assert property (@(posedge clk) disable iff (mreset)
    sel == 3'b010 |-> tc == q[WIDTH-1]);

  a_r5_to_msb: assert property (@(posedge clk) disable iff (mreset)
    sel == 3'b011 |=> q == {$past(q[WIDTH-2:0]), $past(ser_lo_cet_n)});
  a_r5_tc_top: assert property (@(posedge clk) disable iff (mreset)
    sel == 3'b011 |-> tc == q[WIDTH-1]);

  a_r6_up_step: assert property (@(posedge clk) disable iff (mreset)
    (sel == 3'b110 && count_advance) |=> q == $past(q) + ONE);
  a_r6_up_gated: assert property (@(posedge clk) disable iff (mreset)
    (sel == 3'b110 && (cnt_en_n || ser_lo_cet_n)) |=> $stable(q));

  a_r7_down_step: assert property (@(posedge clk) disable iff (mreset)
    (sel == 3'b100 && count_advance) |=> q == $past(q) - ONE);
  a_r7_down_gated: assert property (@(posedge clk) disable iff (mreset)
    (sel == 3'b100 && (cnt_en_n || ser_lo_cet_n)) |=> $stable(q));

  a_r8_up_terminal: assert property (@(posedge clk) disable iff (mreset)
    (sel == 3'b110 && !ser_lo_cet_n && q == '1) |-> !tc);
  a_r8_down_terminal: assert property (@(posedge clk) disable iff (mreset)
    (sel == 3'b100 && !ser_lo_cet_n && q == '0) |-> !tc);
  a_r8_trickle_off: assert property (@(posedge clk) disable iff (mreset)
    ((sel == 3'b110 || sel == 3'b100) && ser_lo_cet_n) |-> tc);

  a_r9_clear: assert property (@(posedge clk) disable iff (mreset)
    sel == 3'b101 |=> q == '0);

  a_r10_hold: assert property (@(posedge clk) disable iff (mreset)
    sel == 3'b111 |=> $stable(q));
  a_r10_tc_high: assert property (@(posedge clk) disable iff (mreset)
    (sel == 3'b111 || sel == 3'b101 || sel == 3'b001) |-> tc);

  a_r11_inverse: assert property (@(posedge clk) q_n == ~q);

endmodule

bind mode_counter_shifter mcs_checker #(.WIDTH(WIDTH)) u_mcs_checker (
  .clk           (clk),
  .mreset        (mreset),
  .sel           (sel),
  .cnt_en_n      (cnt_en_n),
  .ser_lo_cet_n  (ser_lo_cet_n),
  .ser_hi        (ser_hi),
  .preset        (preset),
  .q             (q),
  .q_n           (q_n),
  .tc            (tc),
  .count_advance (count_advance)
);

// File: tb/test_mode_counter_shifter.sv
module test_mode_counter_shifter;

  logic       clk = 1'b0;
  logic       mreset;
  logic [2:0] sel;
  logic       cnt_en_n;
  logic       cet_lo;
  logic       d3_lo, d3_hi;
  logic [3:0] p_lo, p_hi;
  logic [3:0] q_lo, q_hi, qn_lo, qn_hi;
  logic       tc_lo, tc_hi;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  mode_counter_shifter #(.WIDTH(4)) i_mode_counter_shifter (
    .clk(clk), .mreset(mreset), .sel(sel), .cnt_en_n(cnt_en_n),
    .ser_lo_cet_n(cet_lo), .ser_hi(d3_lo), .preset(p_lo),
    .q(q_lo), .q_n(qn_lo), .tc(tc_lo)
  );

  mode_counter_shifter #(.WIDTH(4)) i_upper (
    .clk(clk), .mreset(mreset), .sel(sel), .cnt_en_n(cnt_en_n),
    .ser_lo_cet_n(tc_lo), .ser_hi(d3_hi), .preset(p_hi),
    .q(q_hi), .q_n(qn_hi), .tc(tc_hi)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R7";
      5: return "R9";
      6: return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic int exp_next(input int m, input int s, input int pv,
                                  input int cep, input int cet, input int sh);
    case (m)
      0: return pv;
      1: return 15 - s;
      2: return s / 2 + sh * 8;
      3: return (s * 2 + cet) % 16;
      4: return (cep == 0 && cet == 0) ? (s + 15) % 16 : s;
      5: return 0;
      6: return (cep == 0 && cet == 0) ? (s + 1) % 16 : s;
      default: return s;
    endcase
  endfunction

  function automatic int exp_tc(input int m, input int s, input int cet);
    case (m)
      0: return 0;
      2, 3: return s / 8;
      4: return (cet == 0 && s == 0) ? 0 : 1;
      6: return (cet == 0 && s == 15) ? 0 : 1;
      default: return 1;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp8;
    mreset = 1'b1; sel = 3'b111; cnt_en_n = 1'b0; cet_lo = 1'b0;
    d3_lo = 1'b0; d3_hi = 1'b0; p_lo = 4'd0; p_hi = 4'd0;
    repeat (2) @(posedge clk);
    #1;
    check(q_lo == 4'd0 && q_hi == 4'd0, "R1", {q_hi, q_lo}, 0);
    check(qn_lo == 4'hF, "R11", qn_lo, 15);
    @(negedge clk) mreset = 1'b0;

    // single-stage sweep: every mode, start value, enable pair, high serial bit
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 16; s++) begin
        for (int en = 0; en < 4; en++) begin
          for (int sh = 0; sh < 2; sh++) begin
            int pv, cep, cet;
            pv  = (s * 5 + 3) % 16;
            cep = en % 2;
            cet = en / 2;
            @(negedge clk);
            sel = 3'b000; p_lo = 4'(s);
            @(negedge clk);
            sel = 3'(m); p_lo = 4'(pv); cnt_en_n = cep[0];
            cet_lo = cet[0]; d3_lo = sh[0];
            #1;
            check(int'(tc_lo) == exp_tc(m, s, cet), mode_tag(m) == "R6" ||
                  mode_tag(m) == "R7" ? "R8" : mode_tag(m),
                  int'(tc_lo), exp_tc(m, s, cet));
            @(posedge clk);
            #1;
            check(int'(q_lo) == exp_next(m, s, pv, cep, cet, sh), mode_tag(m),
                  int'(q_lo), exp_next(m, s, pv, cep, cet, sh));
            check(qn_lo == ~q_lo, "R11", int'(qn_lo), int'(~q_lo));
          end
        end
      end
    end

    // R1: reset between edges, then held across a load edge
    @(negedge clk);
    sel = 3'b000; p_lo = 4'd9; p_hi = 4'd6;
    @(posedge clk);
    #1 mreset = 1'b1;
    #0.5;
    check(q_lo == 4'd0 && q_hi == 4'd0, "R1", {q_hi, q_lo}, 0);
    @(posedge clk);
    #1;
    check(q_lo == 4'd0 && q_hi == 4'd0, "R1", {q_hi, q_lo}, 0);
    @(negedge clk) mreset = 1'b0;

    // R12: chained 8-bit count up
    @(negedge clk);
    sel = 3'b101; cnt_en_n = 1'b0; cet_lo = 1'b0;
    @(negedge clk);
    sel = 3'b110;
    exp8 = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk);
      #1;
      exp8 = (exp8 + 1) % 256;
      check({q_hi, q_lo} == 8'(exp8), "R12", {q_hi, q_lo}, exp8);
    end
    // R12: chained 8-bit count down
    @(negedge clk) sel = 3'b100;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk);
      #1;
      exp8 = (exp8 + 255) % 256;
      check({q_hi, q_lo} == 8'(exp8), "R12", {q_hi, q_lo}, exp8);
    end
    // R12: chained 8-bit shift toward the MSB
    @(negedge clk);
    sel = 3'b000; p_lo = 4'd0; p_hi = 4'd0;
    exp8 = 0;
    for (int i = 0; i < 40; i++) begin
      int b;
      b = ((i * 7) % 3 == 0) ? 1 : 0;
      @(negedge clk);
      sel = 3'b011; cet_lo = b[0];
      @(posedge clk);
      #1;
      exp8 = (exp8 * 2 + b) % 256;
      check({q_hi, q_lo} == 8'(exp8), "R12", {q_hi, q_lo}, exp8);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule